// File: doc/BRIEF.md
# Hash compression round engine

This block carries out the 64-round compression of a 256-bit chaining value. The value is held as eight 32-bit words A to H. It completes one round per clock. The word pair for each round is not generated inside the block. The block shows the index of the round it is working on, and the surrounding logic returns the matching message word W and its companion W' in the same cycle. After the last round the eight working words are XORed with the chaining value held from before the block, and the result replaces that value. Because the updated value is kept, any number of blocks can be chained by issuing further starts.

Software or an upstream unit sets the chaining value through a load port while the engine is idle. A one-cycle start pulse then begins a block. Message expansion, padding and the choice of initial value are handled outside.

The controller is a three-state machine:
- `ST_IDLE`: waiting for a start.
- `ST_ROUND`: rounds 0 to 62.
- `ST_LAST`: round 63, including the feed-forward.

Its transitions are:
- T_GO: `ST_IDLE` to `ST_ROUND` on start.
- T_STEP: `ST_ROUND` back to itself.
- T_FINAL: `ST_ROUND` to `ST_LAST` once round 62 is consumed.
- T_FOLD: `ST_LAST` to `ST_IDLE`, which writes the new chaining value and raises done for the next cycle.

Top module: `hash_round_engine`

## Requirements
- R1: While reset is active and after it is released, busy_o and done_o are 0 and state_o is all zeros.
- R2: A load_i pulse in an idle cycle places load_state_i on state_o from the next cycle. Word A is in bits 255:224, then B, C, D, E, F and G in order, and word H is in bits 31:0.
- R3: While busy_o is high, start_i and load_i are ignored. state_o does not change, the running block's result is unaffected, and no extra block follows.
- R4: A start in an idle cycle makes busy_o high for exactly 64 cycles. During those cycles round_o reads 0, 1, ... 63, one value per cycle, and it names the round whose w_i and wp_i are consumed in that cycle.
- R5: done_o is a single-cycle pulse in the first cycle after round 63. In that same cycle state_o already holds the new chaining value.
- R6: Each round j is computed as follows:
  - SS1 = rol(rol(A,12) + E + Kj, 7) and SS2 = SS1 ^ rol(A,12).
  - TT1 = FF + D + SS2 + wp_i and TT2 = GG + H + SS1 + w_i, all modulo 2^32.
  - The new words are A=TT1, B=A, C=rol(B,9), D=C, E=P0(TT2), F=E, G=rol(F,19) and H=G, where P0(x) = x ^ rol(x,9) ^ rol(x,17).
- R7: Kj is the round constant rotated left by j mod 32. The constant is 0x79cc4519 for rounds 0 to 15, with FF = GG = x^y^z. It is 0x7a879d8a for rounds 16 to 63, with FF the bitwise majority and GG = (x&y)|(~x&z).
- R8: The new chaining value is the word-wise XOR of the round-63 output with the chaining value held before the block.
- R9: If load_i and start_i are both high in the same idle cycle, the block starts from load_state_i, and that value is also taken as the chaining value for the feed-forward.
- R10: A start in the cycle where done_o is high is accepted. The new block begins from the chaining value just produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Write load_state_i into the chaining value (idle only) |
| load_state_i | input | 256 | Chaining value to load, A in the top word |
| start_i | input | 1 | Begin compressing one block (idle only) |
| w_i | input | 32 | Message word for the round shown on round_o |
| wp_i | input | 32 | Companion word W' for the round shown on round_o |
| round_o | output | 6 | Index of the round being computed |
| busy_o | output | 1 | High during the 64 round cycles |
| done_o | output | 1 | One-cycle pulse when the new chaining value is valid |
| state_o | output | 256 | Current chaining value |

## Verification
Load and start can fall in the same idle cycle. The bench provokes this by raising both on one edge with a fresh random value. It judges the outcome by the digest: a correct result is only possible if that value both seeded the rounds and served as the feed-forward operand. Start can also coincide with the done pulse. The bench issues the next block on exactly the cycle in which done_o is high, and the scoreboard's expected value is chained from the result just produced, so a lost start or a stale chaining value shows up as a digest mismatch or a missing done. A start and a load raised in mid-block must leave both the result and the next idle cycles unchanged.

// File: rtl/hre_pkg.sv
package hre_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned N_WORDS = 8;
    localparam int unsigned STATE_W = WORD_W * N_WORDS;

    // word slots inside a packed state: A is the most significant word
    localparam int unsigned SLOT_A = 7;
    localparam int unsigned SLOT_B = 6;
    localparam int unsigned SLOT_C = 5;
    localparam int unsigned SLOT_D = 4;
    localparam int unsigned SLOT_E = 3;
    localparam int unsigned SLOT_F = 2;
    localparam int unsigned SLOT_G = 1;
    localparam int unsigned SLOT_H = 0;

    typedef logic [WORD_W-1:0]               word_t;
    typedef logic [N_WORDS-1:0][WORD_W-1:0]  hstate_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ROUND = 2'd1,
        ST_LAST  = 2'd2
    } hre_state_e;

    // left rotate by a constant amount between 1 and WORD_W-1
    function automatic word_t rotl(input word_t x, input int unsigned n);
        rotl = (x << n) | (x >> (WORD_W - n));
    endfunction

endpackage

// File: rtl/hre_ctrl.sv
module hre_ctrl
    import hre_pkg::*;
#(
    parameter  int unsigned ROUNDS  = 64,
    localparam int unsigned ROUND_W = $clog2(ROUNDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    output logic               accept_o,
    output logic               busy_o,
    output logic               last_o,
    output logic               done_o,
    output logic [ROUND_W-1:0] round_o
);

    localparam logic [ROUND_W-1:0] PEN_ROUND = ROUND_W'(ROUNDS - 2);

    hre_state_e         state_q, state_d;
    logic [ROUND_W-1:0] round_q;
    logic               done_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_ROUND;              // T_GO
                end
            end
            ST_ROUND: begin
                if (round_q == PEN_ROUND) begin
                    state_d = ST_LAST;               // T_FINAL
                end else begin
                    state_d = ST_ROUND;              // T_STEP
                end
            end
            ST_LAST: begin
                state_d = ST_IDLE;                   // T_FOLD
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        accept_o = (state_q == ST_IDLE) && start_i;
        busy_o   = (state_q != ST_IDLE);
        last_o   = (state_q == ST_LAST);
        done_o   = done_q;
        round_o  = round_q;
    end

    // round index and the registered completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            round_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (state_q == ST_LAST);
            if (accept_o) begin
                round_q <= '0;
            end else if (busy_o) begin
                round_q <= round_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hre_const_rot.sv
module hre_const_rot
    import hre_pkg::*;
#(
    parameter int unsigned ROUND_W      = 6,
    parameter int unsigned SWITCH_ROUND = 16,
    parameter word_t       T_LOW        = 32'h79cc4519,
    parameter word_t       T_HIGH       = 32'h7a879d8a
) (
    input  logic [ROUND_W-1:0] round_i,
    output word_t              k_rot_o,
    output logic               late_o
);

    localparam int unsigned SH_W = $clog2(WORD_W);

    word_t stage [SH_W+1];

    assign late_o   = (round_i >= ROUND_W'(SWITCH_ROUND));
    assign stage[0] = late_o ? T_HIGH : T_LOW;

    // log-depth rotator: stage s rotates left by 2^s when round bit s is set
    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        localparam int unsigned AMT = 1 << s;
        logic sel;
        if (s < ROUND_W) begin : g_bit
            assign sel = round_i[s];
        end else begin : g_zero
            assign sel = 1'b0;
        end
        assign stage[s+1] = sel ? {stage[s][WORD_W-1-AMT:0], stage[s][WORD_W-1 -: AMT]}
                                : stage[s];
    end

    assign k_rot_o = stage[SH_W];

endmodule

// File: rtl/hre_round.sv
module hre_round
    import hre_pkg::*;
(
    input  hstate_t cur_i,
    input  word_t   k_i,
    input  logic    late_i,
    input  word_t   w_i,
    input  word_t   wp_i,
    output hstate_t nxt_o
);

    word_t a, b, c, d, e, f, g, h;
    word_t a_rot, ss1, ss2, ff, gg, tt1, tt2, p0;

    always_comb begin
        a = cur_i[SLOT_A];
        b = cur_i[SLOT_B];
        c = cur_i[SLOT_C];
        d = cur_i[SLOT_D];
        e = cur_i[SLOT_E];
        f = cur_i[SLOT_F];
        g = cur_i[SLOT_G];
        h = cur_i[SLOT_H];

        a_rot = rotl(a, 12);
        ss1   = rotl(a_rot + e + k_i, 7);
        ss2   = ss1 ^ a_rot;

        if (late_i) begin
            ff = (a & b) | (a & c) | (b & c);
            gg = (e & f) | (~e & g);
        end else begin
            ff = a ^ b ^ c;
            gg = e ^ f ^ g;
        end

        tt1 = ff + d + ss2 + wp_i;
        tt2 = gg + h + ss1 + w_i;
        p0  = tt2 ^ rotl(tt2, 9) ^ rotl(tt2, 17);

        nxt_o         = '0;
        nxt_o[SLOT_A] = tt1;
        nxt_o[SLOT_B] = a;
        nxt_o[SLOT_C] = rotl(b, 9);
        nxt_o[SLOT_D] = c;
        nxt_o[SLOT_E] = p0;
        nxt_o[SLOT_F] = e;
        nxt_o[SLOT_G] = rotl(f, 19);
        nxt_o[SLOT_H] = g;
    end

endmodule

// File: rtl/hash_round_engine.sv
module hash_round_engine
    import hre_pkg::*;
#(
    parameter  int unsigned ROUNDS       = 64,
    parameter  int unsigned SWITCH_ROUND = 16,
    parameter  logic [31:0] T_LOW        = 32'h79cc4519,
    parameter  logic [31:0] T_HIGH       = 32'h7a879d8a,
    localparam int unsigned ROUND_W      = $clog2(ROUNDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [255:0]       load_state_i,
    input  logic               start_i,
    input  logic [31:0]        w_i,
    input  logic [31:0]        wp_i,
    output logic [ROUND_W-1:0] round_o,
    output logic               busy_o,
    output logic               done_o,
    output logic [255:0]       state_o
);

    logic               accept, busy, last, done;
    logic [ROUND_W-1:0] rnd;
    logic               load_ok;
    logic               late;
    word_t              k_rot;
    hstate_t            chain_q, work_q, round_nxt, fold;

    hre_ctrl #(
        .ROUNDS (ROUNDS)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .busy_o   (busy),
        .last_o   (last),
        .done_o   (done),
        .round_o  (rnd)
    );

    hre_const_rot #(
        .ROUND_W      (ROUND_W),
        .SWITCH_ROUND (SWITCH_ROUND),
        .T_LOW        (T_LOW),
        .T_HIGH       (T_HIGH)
    ) u_krot (
        .round_i (rnd),
        .k_rot_o (k_rot),
        .late_o  (late)
    );

    hre_round u_round (
        .cur_i  (work_q),
        .k_i    (k_rot),
        .late_i (late),
        .w_i    (w_i),
        .wp_i   (wp_i),
        .nxt_o  (round_nxt)
    );

    assign load_ok = load_i && !busy;

    // feed-forward: word-wise XOR with the value held before the block
    for (genvar gi = 0; gi < N_WORDS; gi++) begin : g_fold
        assign fold[gi] = round_nxt[gi] ^ chain_q[gi];
    end

    // chaining value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (load_ok) begin
            chain_q <= load_state_i;
        end else if (last) begin
            chain_q <= fold;
        end
    end

    // working words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work_q <= '0;
        end else if (accept) begin
            work_q <= load_ok ? hstate_t'(load_state_i) : chain_q;
        end else if (busy) begin
            work_q <= round_nxt;
        end
    end

    assign round_o = rnd;
    assign busy_o  = busy;
    assign done_o  = done;
    assign state_o = chain_q;

endmodule

// File: rtl/hash_round_engine_chk.sv
module hash_round_engine_chk #(
    parameter  int unsigned ROUNDS  = 64,
    localparam int unsigned ROUND_W = $clog2(ROUNDS),
    localparam int unsigned CNT_W   = ROUND_W + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy_o,
    input logic               done_o,
    input logic [ROUND_W-1:0] round_o,
    input logic [255:0]       state_o
);

    logic [CNT_W-1:0] busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_len <= '0;
        end else if (busy_o) begin
            busy_len <= busy_len + 1'b1;
        end else begin
            busy_len <= '0;
        end
    end

    // R4: a block keeps busy_o high for exactly ROUNDS cycles
    a_r4_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> busy_len == CNT_W'(ROUNDS));

    a_r4_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> busy_len < CNT_W'(ROUNDS));

    // R4: round index starts at zero and steps by one
    a_r4_round_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> round_o == '0);

    a_r4_round_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> round_o == ROUND_W'($past(round_o) + 1'b1));

    // R5: done is a single pulse right after the busy window
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r5_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $fell(busy_o));

    // R3: chaining value untouched while rounds run
    a_r3_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(state_o));

endmodule

bind hash_round_engine hash_round_engine_chk #(
    .ROUNDS (ROUNDS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .round_o (round_o),
    .state_o (state_o)
);

// File: tb/hash_round_engine_tb_top.sv
`timescale 1ns/1ps
module hash_round_engine_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [255:0] load_state_i = '0;
    logic         start_i = 1'b0;
    logic [31:0]  w_i, wp_i;
    logic [5:0]   round_o;
    logic         busy_o, done_o;
    logic [255:0] state_o;

    logic [31:0]  cur_w  [64];
    logic [31:0]  cur_wp [64];

    int           n_checks = 0;
    int           n_fails  = 0;
    logic [255:0] model_chain = '0;
    logic [255:0] exp_q [$];
    string        tag_q [$];

    localparam logic [255:0] IV = {32'h7380166f, 32'h4914b2b9, 32'h172442d7, 32'hda8a0600,
                                   32'ha96f30bc, 32'h163138aa, 32'he38dee4d, 32'hb0fb0e4e};
    localparam logic [255:0] ABC_DIGEST = {32'h66c7f0f4, 32'h62eeedd9, 32'hd1f2d46b, 32'hdc10e4e2,
                                           32'h4167c487, 32'h5cf2f7a2, 32'h297da02b, 32'h8f4ba8e0};

    always #5 clk = ~clk;

    assign w_i  = cur_w[round_o];
    assign wp_i = cur_wp[round_o];

    hash_round_engine dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_i),
        .load_state_i (load_state_i),
        .start_i      (start_i),
        .w_i          (w_i),
        .wp_i         (wp_i),
        .round_o      (round_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .state_o      (state_o)
    );

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (n == 0) ? x : ((x << n) | (x >> (32 - n)));
    endfunction

    function automatic logic [255:0] ref_block(input logic [255:0] v,
                                               input logic [31:0] wv [64],
                                               input logic [31:0] wpv [64]);
        logic [31:0] a, b, c, d, e, f, g, h, ss1, ss2, tt1, tt2, ff, gg, t;
        {a, b, c, d, e, f, g, h} = v;
        for (int j = 0; j < 64; j++) begin
            t   = (j < 16) ? 32'h79cc4519 : 32'h7a879d8a;
            ss1 = rl(rl(a, 12) + e + rl(t, j % 32), 7);
            ss2 = ss1 ^ rl(a, 12);
            if (j < 16) begin
                ff = a ^ b ^ c;
                gg = e ^ f ^ g;
            end else begin
                ff = (a & b) | (a & c) | (b & c);
                gg = (e & f) | (~e & g);
            end
            tt1 = ff + d + ss2 + wpv[j];
            tt2 = gg + h + ss1 + wv[j];
            d = c; c = rl(b, 9); b = a; a = tt1;
            h = g; g = rl(f, 19); f = e; e = tt2 ^ rl(tt2, 9) ^ rl(tt2, 17);
        end
        return {a, b, c, d, e, f, g, h} ^ v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expand one 16-word message into the 64 word pairs
    task automatic set_message(input logic [31:0] m [16]);
        logic [31:0] wx [68];
        logic [31:0] x;
        for (int i = 0; i < 16; i++) wx[i] = m[i];
        for (int i = 16; i < 68; i++) begin
            x = wx[i-16] ^ wx[i-9] ^ rl(wx[i-3], 15);
            wx[i] = (x ^ rl(x, 15) ^ rl(x, 23)) ^ rl(wx[i-13], 7) ^ wx[i-6];
        end
        for (int i = 0; i < 64; i++) begin
            cur_w[i]  = wx[i];
            cur_wp[i] = wx[i] ^ wx[i+4];
        end
    endtask

    task automatic fill_words(input int kind);
        for (int i = 0; i < 64; i++) begin
            case (kind)
                0:       begin cur_w[i] = '0;           cur_wp[i] = '0;           end
                1:       begin cur_w[i] = '1;           cur_wp[i] = '1;           end
                default: begin cur_w[i] = $urandom();   cur_wp[i] = $urandom();   end
            endcase
        end
    endtask

    // driver: push expectation, then pulse start (called at a negedge)
    task automatic start_block(input string tag);
        logic [255:0] e;
        e = ref_block(model_chain, cur_w, cur_wp);
        model_chain = e;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
    endtask

    // monitor: compares every result against the scoreboard
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected done", state_o, '0);
            end else begin
                logic [255:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(state_o === e, {t, " R6 R7 R8 block result"}, state_o, e);
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] m [16];
        int n;
        fill_words(0);
        repeat (3) @(negedge clk);
        // R1: reset values
        check(busy_o === 1'b0 && done_o === 1'b0, "R1 reset flags", {254'd0, busy_o, done_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(state_o === '0, "R1 reset state", state_o, '0);

        // R2: load in idle
        load_state_i = IV;
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        model_chain = IV;
        check(state_o === IV, "R2 load", state_o, IV);

        // known one-block message "abc"
        for (int i = 0; i < 16; i++) m[i] = '0;
        m[0]  = 32'h61626380;
        m[15] = 32'h00000018;
        set_message(m);
        start_block("abc");
        n = 1;
        check(busy_o === 1'b1, "R4 busy after start", {255'd0, busy_o}, 256'd1);
        while (!done_o) begin
            @(negedge clk);
            n++;
        end
        check(n == 65, "R4 latency 64 rounds", 256'(n), 256'd65);
        // R7 R8: digest of the standard three-byte message
        check(state_o === ABC_DIGEST, "R7 known digest", state_o, ABC_DIGEST);

        // R10: next block started in the done cycle, chained from that result
        fill_words(2);
        start_block("R10 back-to-back");
        check(done_o === 1'b0, "R5 done single pulse", {255'd0, done_o}, '0);
        wait_done();
        fill_words(0);
        start_block("R10 chained zero words");
        wait_done();
        @(negedge clk);

        // R3: start and load while busy are ignored
        fill_words(1);
        start_block("R3 busy ignore");
        repeat (10) @(negedge clk);
        start_i = 1'b1;
        load_i = 1'b1;
        load_state_i = {8{32'hdeadbeef}};
        @(negedge clk);
        start_i = 1'b0;
        load_i = 1'b0;
        wait_done();
        repeat (70) @(negedge clk);
        check(busy_o === 1'b0, "R3 no extra block", {255'd0, busy_o}, '0);
        check(state_o === model_chain, "R3 state kept", state_o, model_chain);

        // R9: load and start in the same idle cycle
        load_state_i = {$urandom(), $urandom(), $urandom(), $urandom(),
                        $urandom(), $urandom(), $urandom(), $urandom()};
        model_chain = load_state_i;
        fill_words(2);
        load_i = 1'b1;
        start_block("R9 load with start");
        load_i = 1'b0;
        wait_done();
        @(negedge clk);

        // more random blocks, some with idle gaps
        for (int k = 0; k < 4; k++) begin
            fill_words(2);
            start_block("R6 random");
            wait_done();
            repeat (k) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R5 every block done", 256'(exp_q.size()), '0);
        finish_run();
    end

endmodule